// File: doc/BRIEF.md
# SAR ADC Sequencing Controller

This block is the digital half of an eight-input, 10-bit successive-approximation converter. It selects the analog input and drives a trial code to the external DAC. One comparator bit comes back each step, and the block resolves the code from the most significant bit down. Each finished code goes into a result slot that belongs to the channel it was taken from. The comparator, the DAC and the sample-and-hold sit outside the block.

A conversion can start in four ways. Software can pulse a start line. A chosen edge on an external pin can start one, and so can a pulse from a timer. In burst mode the block sweeps the channels enabled in a mask, over and over, with no further requests. A clock-enable input sets the conversion rate. Every conversion takes one sample step and then one step per bit, so a 4.4 MHz enable rate gives 400 000 samples per second. Each slot has a done flag that clears when the slot is read. It also has an overrun flag for results that were lost before anyone read them. A per-channel enable mask combines the done flags into one interrupt.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After the sample step, `trial` is the code with only the MSB set. On each enabled bit step the current bit is kept when `cmp_in` is 1 and cleared when it is 0, and the next lower bit is then set. With an ideal comparator (`cmp_in` = input >= `trial`) the stored result equals the input code, for every code from 0 to 1023.
- R2: The block accepts a start at a clock edge while idle. The conversion then uses exactly 11 further `cclk_en` cycles: one to sample and ten to decide bits. `busy` stays high for the whole conversion. The done flag is visible right after the 11th of those edges, and not before.
- R3: The block captures `chan_sel` when it accepts a start. `ana_chan` keeps that value for the whole conversion. The result is written only into that channel's slot, and the other slots keep their contents.
- R4: While `burst_en` is 1 and the mask is not zero, the block converts the enabled channels in ascending index order. It wraps from the highest enabled channel back to the lowest. Each new sample step follows the previous one by exactly 11 cycles, and this also holds when the mask has a single bit set. If the mask is zero, the block stays idle. Clearing `burst_en` lets the current conversion finish, and then the block stops.
- R5: When `trig_sel` bit 0 is 1, an edge on `ext_pin` starts a conversion. The edge is rising when `pin_fall` is 0 and falling when `pin_fall` is 1. The opposite edge has no effect.
- R6: When `trig_sel` bit 1 is 1, a one-cycle `timer_match` pulse starts a conversion. When that bit is 0, the pulse has no effect.
- R7: Hardware triggers and `sw_start` are ignored while a conversion is in progress or while `burst_en` is 1. No conversion is queued for later.
- R8: A `rd_en` cycle shows the addressed slot's code, done and overrun bits on `rd_data`, `rd_done` and `rd_ovr` in the same cycle. From the next cycle both flags of that slot read 0.
- R9: A result written into a slot whose done flag is still 1 sets that slot's overrun flag.
- R10: `irq` is 1 exactly when some channel has both its done flag and its `irq_en` bit set. With `irq_en` all zero, `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cclk_en | input | 1 | Conversion-step enable; one step per enabled cycle |
| sw_start | input | 1 | Software start pulse |
| chan_sel | input | 3 | Channel used by software and hardware starts |
| burst_en | input | 1 | Continuous sweep over `chan_mask` |
| chan_mask | input | 8 | Channels enabled for burst |
| trig_sel | input | 2 | Bit 0: pin edge starts; bit 1: timer match starts |
| pin_fall | input | 1 | Pin edge polarity: 0 rising, 1 falling |
| ext_pin | input | 1 | External start pin (synchronous to `clk`) |
| timer_match | input | 1 | Timer match pulse |
| cmp_in | input | 1 | Comparator: 1 when input >= `trial` |
| ana_chan | output | 3 | Channel routed to the sample-and-hold |
| trial | output | 10 | Trial code driven to the DAC |
| sample | output | 1 | High during the sample step |
| busy | output | 1 | Conversion in progress |
| rd_en | input | 1 | Read strobe; clears the addressed slot's flags |
| rd_chan | input | 3 | Slot being read |
| rd_data | output | 10 | Code held in the addressed slot |
| rd_done | output | 1 | Done flag of the addressed slot |
| rd_ovr | output | 1 | Overrun flag of the addressed slot |
| done_vec | output | 8 | Done flags of all slots |
| ovr_vec | output | 8 | Overrun flags of all slots |
| irq_en | input | 8 | Per-channel interrupt enables |
| irq | output | 1 | Combined interrupt |

## Verification
Each fault in this block is visible at the ports within one conversion.

- A wrong search register gives a wrong code on `rd_data` as soon as the slot is read.
- A miscounted bit index moves the done flag off the 11th step, so it is caught at that edge.
- A bad burst selector makes the channel sequence seen at each `sample` pulse disagree with the mask order, or makes the gap between pulses differ from 11 cycles.
- Faulty slot flags appear as a wrong `rd_done`/`rd_ovr` on the next read, or as a wrong `irq` in the cycle after the write.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SAMPLE = 2'd1,
      ST_BITS   = 2'd2
   } sar_state_e;
endpackage

// File: rtl/sar_start_logic.sv
`timescale 1ns/1ps
module sar_start_logic #(
   parameter int PIN_SYNC = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sw_start,
   input  logic [1:0] trig_sel,
   input  logic       pin_fall,
   input  logic       ext_pin,
   input  logic       timer_match,
   input  logic       eng_busy,
   input  logic       burst_en,
   output logic       start_req
);
   logic pin_s;
   logic pin_prev;
   logic pin_edge;
   logic hw_hit;

   generate
      if (PIN_SYNC == 0) begin : g_nosync
         assign pin_s = ext_pin;
      end else begin : g_sync
         logic [PIN_SYNC-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain[0] <= ext_pin;
               for (int k = 1; k < PIN_SYNC; k++) chain[k] <= chain[k-1];
            end
         end
         assign pin_s = chain[PIN_SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev <= 1'b0;
      else        pin_prev <= pin_s;
   end

   assign pin_edge  = pin_fall ? (pin_prev & ~pin_s) : (~pin_prev & pin_s);
   assign hw_hit    = (trig_sel[0] & pin_edge) | (trig_sel[1] & timer_match);
   assign start_req = ~eng_busy & ~burst_en & (sw_start | hw_hit);
endmodule

// File: rtl/sar_burst_pick.sv
`timescale 1ns/1ps
module sar_burst_pick #(
   parameter int N_CH = 8,
   parameter int CH_W = 3
) (
   input  logic [N_CH-1:0] mask,
   input  logic [CH_W-1:0] cur,
   output logic            any_en,
   output logic [CH_W-1:0] first,
   output logic [CH_W-1:0] next
);
   logic found;

   always_comb begin
      any_en = |mask;
      first  = '0;
      next   = '0;
      found  = 1'b0;
      for (int i = N_CH - 1; i >= 0; i--) begin
         if (mask[i]) first = CH_W'(i);
      end
      for (int i = N_CH - 1; i >= 0; i--) begin
         if (mask[i] && (i > int'(cur))) begin
            next  = CH_W'(i);
            found = 1'b1;
         end
      end
      if (!found) next = first;
   end
endmodule

// File: rtl/sar_step_engine.sv
`timescale 1ns/1ps
module sar_step_engine
   import sar_seq_pkg::*;
#(
   parameter int RES_W = 10,
   parameter int CH_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cclk_en,
   input  logic             start_req,
   input  logic [CH_W-1:0]  start_chan,
   input  logic             burst_go,
   input  logic [CH_W-1:0]  burst_first,
   input  logic [CH_W-1:0]  burst_next,
   input  logic             cmp_in,
   output logic             eng_busy,
   output logic             sample,
   output logic [RES_W-1:0] trial,
   output logic [CH_W-1:0]  chan,
   output logic             wr_en,
   output logic [RES_W-1:0] wr_data
);
   localparam int IDX_W = $clog2(RES_W);
   localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

   sar_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic [RES_W-1:0] trial_q;
   logic [CH_W-1:0]  chan_q;
   logic [RES_W-1:0] decided;
   logic [RES_W-1:0] probe;
   logic             bit_last;

   assign bit_last = (idx_q == '0);

   always_comb begin
      decided = trial_q;
      if (!cmp_in) decided[idx_q] = 1'b0;
      probe = decided;
      probe[IDX_W'(idx_q - 1'b1)] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         trial_q <= '0;
         chan_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (burst_go) begin
                  chan_q  <= burst_first;
                  state_q <= ST_SAMPLE;
               end else if (start_req) begin
                  chan_q  <= start_chan;
                  state_q <= ST_SAMPLE;
               end
            end
            ST_SAMPLE: begin
               if (cclk_en) begin
                  trial_q <= MSB_ONLY;
                  idx_q   <= IDX_W'(RES_W - 1);
                  state_q <= ST_BITS;
               end
            end
            ST_BITS: begin
               if (cclk_en) begin
                  if (bit_last) begin
                     trial_q <= decided;
                     if (burst_go) begin
                        chan_q  <= burst_next;
                        state_q <= ST_SAMPLE;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end else begin
                     trial_q <= probe;
                     idx_q   <= idx_q - 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign eng_busy = (state_q != ST_IDLE);
   assign sample   = (state_q == ST_SAMPLE);
   assign trial    = trial_q;
   assign chan     = chan_q;
   assign wr_en    = (state_q == ST_BITS) && cclk_en && bit_last;
   assign wr_data  = decided;
endmodule

// File: rtl/sar_result_bank.sv
`timescale 1ns/1ps
module sar_result_bank #(
   parameter int N_CH  = 8,
   parameter int RES_W = 10,
   parameter int CH_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CH_W-1:0]  wr_chan,
   input  logic [RES_W-1:0] wr_data,
   input  logic             rd_en,
   input  logic [CH_W-1:0]  rd_chan,
   output logic [RES_W-1:0] rd_data,
   output logic             rd_done,
   output logic             rd_ovr,
   output logic [N_CH-1:0]  done_vec,
   output logic [N_CH-1:0]  ovr_vec
);
   logic [RES_W-1:0] code_q [N_CH];

   generate
      for (genvar g = 0; g < N_CH; g++) begin : g_slot
         logic wr_hit;
         logic rd_hit;
         assign wr_hit = wr_en && (wr_chan == CH_W'(g));
         assign rd_hit = rd_en && (rd_chan == CH_W'(g));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               code_q[g]   <= '0;
               done_vec[g] <= 1'b0;
               ovr_vec[g]  <= 1'b0;
            end else if (wr_hit) begin
               code_q[g]   <= wr_data;
               done_vec[g] <= 1'b1;
               ovr_vec[g]  <= rd_hit ? 1'b0 : (ovr_vec[g] | done_vec[g]);
            end else if (rd_hit) begin
               done_vec[g] <= 1'b0;
               ovr_vec[g]  <= 1'b0;
            end
         end
      end
   endgenerate

   assign rd_data = code_q[rd_chan];
   assign rd_done = done_vec[rd_chan];
   assign rd_ovr  = ovr_vec[rd_chan];
endmodule

// File: rtl/sar_seq_ctrl.sv
`timescale 1ns/1ps
module sar_seq_ctrl #(
   parameter int RES_W    = 10,
   parameter int N_CH     = 8,
   parameter int PIN_SYNC = 0,
   localparam int CH_W    = $clog2(N_CH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cclk_en,
   input  logic             sw_start,
   input  logic [CH_W-1:0]  chan_sel,
   input  logic             burst_en,
   input  logic [N_CH-1:0]  chan_mask,
   input  logic [1:0]       trig_sel,
   input  logic             pin_fall,
   input  logic             ext_pin,
   input  logic             timer_match,
   input  logic             cmp_in,
   output logic [CH_W-1:0]  ana_chan,
   output logic [RES_W-1:0] trial,
   output logic             sample,
   output logic             busy,
   input  logic             rd_en,
   input  logic [CH_W-1:0]  rd_chan,
   output logic [RES_W-1:0] rd_data,
   output logic             rd_done,
   output logic             rd_ovr,
   output logic [N_CH-1:0]  done_vec,
   output logic [N_CH-1:0]  ovr_vec,
   input  logic [N_CH-1:0]  irq_en,
   output logic             irq
);
   generate
      if (RES_W < 2 || RES_W > 16) begin : g_bad_res
         $error("sar_seq_ctrl: RES_W must lie in 2..16");
      end
      if (N_CH < 2 || N_CH != (1 << CH_W)) begin : g_bad_ch
         $error("sar_seq_ctrl: N_CH must be a power of two, at least 2");
      end
      if (PIN_SYNC < 0 || PIN_SYNC > 4) begin : g_bad_sync
         $error("sar_seq_ctrl: PIN_SYNC must lie in 0..4");
      end
   endgenerate

   logic             eng_busy;
   logic             start_req;
   logic             any_en;
   logic             burst_go;
   logic [CH_W-1:0]  b_first;
   logic [CH_W-1:0]  b_next;
   logic [CH_W-1:0]  cur_chan;
   logic             wr_en;
   logic [RES_W-1:0] wr_data;

   assign burst_go = burst_en & any_en;

   sar_start_logic #(.PIN_SYNC(PIN_SYNC)) u_start (
      .clk         (clk),
      .rst_n       (rst_n),
      .sw_start    (sw_start),
      .trig_sel    (trig_sel),
      .pin_fall    (pin_fall),
      .ext_pin     (ext_pin),
      .timer_match (timer_match),
      .eng_busy    (eng_busy),
      .burst_en    (burst_en),
      .start_req   (start_req)
   );

   sar_burst_pick #(.N_CH(N_CH), .CH_W(CH_W)) u_pick (
      .mask   (chan_mask),
      .cur    (cur_chan),
      .any_en (any_en),
      .first  (b_first),
      .next   (b_next)
   );

   sar_step_engine #(.RES_W(RES_W), .CH_W(CH_W)) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .cclk_en     (cclk_en),
      .start_req   (start_req),
      .start_chan  (chan_sel),
      .burst_go    (burst_go),
      .burst_first (b_first),
      .burst_next  (b_next),
      .cmp_in      (cmp_in),
      .eng_busy    (eng_busy),
      .sample      (sample),
      .trial       (trial),
      .chan        (cur_chan),
      .wr_en       (wr_en),
      .wr_data     (wr_data)
   );

   sar_result_bank #(.N_CH(N_CH), .RES_W(RES_W), .CH_W(CH_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_chan  (cur_chan),
      .wr_data  (wr_data),
      .rd_en    (rd_en),
      .rd_chan  (rd_chan),
      .rd_data  (rd_data),
      .rd_done  (rd_done),
      .rd_ovr   (rd_ovr),
      .done_vec (done_vec),
      .ovr_vec  (ovr_vec)
   );

   assign busy     = eng_busy;
   assign ana_chan = cur_chan;
   assign irq      = |(done_vec & irq_en);
endmodule

// File: rtl/sar_seq_checker.sv
`timescale 1ns/1ps
module sar_seq_checker #(
   parameter int RES_W = 10,
   parameter int N_CH  = 8,
   parameter int CH_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cclk_en,
   input logic             burst_en,
   input logic [N_CH-1:0]  chan_mask,
   input logic             sample,
   input logic             busy,
   input logic [RES_W-1:0] trial,
   input logic [CH_W-1:0]  ana_chan,
   input logic [N_CH-1:0]  done_vec,
   input logic [N_CH-1:0]  ovr_vec,
   input logic [N_CH-1:0]  irq_en,
   input logic             irq
);
   localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

   assert_trial_msb_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && cclk_en) |=> (trial == MSB_ONLY))
      else $error("R1: trial not MSB-only after sample step");

   assert_chan_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !sample) |-> $stable(ana_chan))
      else $error("R3: channel changed during bit steps");

   assert_empty_mask_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && burst_en && (chan_mask == '0)) |=> !busy)
      else $error("R4: conversion started with empty burst mask");

   generate
      for (genvar g = 0; g < N_CH; g++) begin : g_ovr
         assert_ovr_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovr_vec[g]) |-> $past(done_vec[g]))
            else $error("R9: overrun set without prior done");
      end
   endgenerate

   assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == '0) |-> !irq)
      else $error("R10: irq with all enables clear");
endmodule

bind sar_seq_ctrl sar_seq_checker #(.RES_W(RES_W), .N_CH(N_CH), .CH_W(CH_W)) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cclk_en   (cclk_en),
   .burst_en  (burst_en),
   .chan_mask (chan_mask),
   .sample    (sample),
   .busy      (busy),
   .trial     (trial),
   .ana_chan  (ana_chan),
   .done_vec  (done_vec),
   .ovr_vec   (ovr_vec),
   .irq_en    (irq_en),
   .irq       (irq)
);

// File: tb/test_sar_seq_ctrl.sv
`timescale 1ns/1ps
module test_sar_seq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cclk_en = 1'b1;
   logic       sw_start = 1'b0;
   logic [2:0] chan_sel = '0;
   logic       burst_en = 1'b0;
   logic [7:0] chan_mask = '0;
   logic [1:0] trig_sel = '0;
   logic       pin_fall = 1'b0;
   logic       ext_pin = 1'b0;
   logic       timer_match = 1'b0;
   logic       cmp_in;
   logic [2:0] ana_chan;
   logic [9:0] trial;
   logic       sample;
   logic       busy;
   logic       rd_en = 1'b0;
   logic [2:0] rd_chan = '0;
   logic [9:0] rd_data;
   logic       rd_done;
   logic       rd_ovr;
   logic [7:0] done_vec;
   logic [7:0] ovr_vec;
   logic [7:0] irq_en = '0;
   logic       irq;

   logic [9:0] vin [8];
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   assign cmp_in = (vin[ana_chan] >= trial);

   sar_seq_ctrl i_sar_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .cclk_en(cclk_en), .sw_start(sw_start),
      .chan_sel(chan_sel), .burst_en(burst_en), .chan_mask(chan_mask),
      .trig_sel(trig_sel), .pin_fall(pin_fall), .ext_pin(ext_pin),
      .timer_match(timer_match), .cmp_in(cmp_in), .ana_chan(ana_chan),
      .trial(trial), .sample(sample), .busy(busy), .rd_en(rd_en),
      .rd_chan(rd_chan), .rd_data(rd_data), .rd_done(rd_done), .rd_ovr(rd_ovr),
      .done_vec(done_vec), .ovr_vec(ovr_vec), .irq_en(irq_en), .irq(irq)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic start_sw(input int ch);
      @(negedge clk);
      sw_start = 1'b1;
      chan_sel = 3'(ch);
      @(negedge clk);
      sw_start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 40; n++) begin
         if (!busy) break;
         @(negedge clk);
      end
   endtask

   task automatic read_chk(input int ch, input int code, input int dn, input int ov, input string req);
      @(negedge clk);
      rd_en = 1'b1;
      rd_chan = 3'(ch);
      #1;
      chk(req, $sformatf("rd_data ch%0d", ch), int'(rd_data), code);
      chk(req, $sformatf("rd_done ch%0d", ch), int'(rd_done), dn);
      chk(req, $sformatf("rd_ovr ch%0d", ch), int'(rd_ovr), ov);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic clear_all();
      for (int c = 0; c < 8; c++) begin
         @(negedge clk);
         rd_en = 1'b1;
         rd_chan = 3'(c);
      end
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // R1 R2 R3: software conversion with exact latency
   task automatic t_sw_conv(input int ch, input int val);
      vin[ch] = 10'(val);
      start_sw(ch);
      chk("R3", "busy after start", int'(busy), 1);
      chk("R3", "ana_chan", int'(ana_chan), ch);
      repeat (10) @(negedge clk);
      chk("R2", "done not before 11th step", int'(done_vec[ch]), 0);
      @(negedge clk);
      chk("R2", "done after 11th step", int'(done_vec[ch]), 1);
      chk("R2", "busy cleared", int'(busy), 0);
      read_chk(ch, val, 1, 0, "R1");
   endtask

   task automatic t_reset();
      chk("R2", "busy at reset", int'(busy), 0);
      chk("R8", "done_vec at reset", int'(done_vec), 0);
      chk("R9", "ovr_vec at reset", int'(ovr_vec), 0);
      chk("R10", "irq at reset", int'(irq), 0);
   endtask

   task automatic t_isolation();
      vin[1] = 10'd100;
      vin[4] = 10'd900;
      start_sw(1); wait_idle();
      start_sw(4); wait_idle();
      read_chk(1, 100, 1, 0, "R3");
      read_chk(4, 900, 1, 0, "R3");
   endtask

   task automatic t_sw_busy_ignored();
      vin[5] = 10'd200;
      start_sw(5);
      repeat (2) @(negedge clk);
      sw_start = 1'b1; chan_sel = 3'd6;
      @(negedge clk);
      sw_start = 1'b0;
      wait_idle();
      @(negedge clk);
      chk("R7", "no queued start busy", int'(busy), 0);
      chk("R7", "ch6 untouched", int'(done_vec[6]), 0);
      read_chk(5, 200, 1, 0, "R7");
   endtask

   task automatic t_overrun();
      vin[3] = 10'd77;
      start_sw(3); wait_idle();
      vin[3] = 10'd78;
      start_sw(3); wait_idle();
      @(negedge clk);
      chk("R9", "ovr_vec[3]", int'(ovr_vec[3]), 1);
      read_chk(3, 78, 1, 1, "R9");
      read_chk(3, 78, 0, 0, "R8");
   endtask

   task automatic t_pin_edges();
      vin[2] = 10'd640;
      trig_sel = 2'b01; pin_fall = 1'b0; chan_sel = 3'd2;
      @(negedge clk); ext_pin = 1'b1;
      @(negedge clk);
      chk("R5", "rising edge starts", int'(busy), 1);
      wait_idle();
      read_chk(2, 640, 1, 0, "R5");
      @(negedge clk); ext_pin = 1'b0;
      @(negedge clk);
      chk("R5", "falling ignored in rising mode", int'(busy), 0);
      pin_fall = 1'b1;
      @(negedge clk); ext_pin = 1'b1;
      @(negedge clk);
      chk("R5", "rising ignored in falling mode", int'(busy), 0);
      @(negedge clk); ext_pin = 1'b0;
      @(negedge clk);
      chk("R5", "falling edge starts", int'(busy), 1);
      wait_idle();
      read_chk(2, 640, 1, 0, "R5");
      pin_fall = 1'b0; trig_sel = 2'b00;
   endtask

   task automatic t_timer();
      vin[6] = 10'd5;
      chan_sel = 3'd6;
      trig_sel = 2'b01;
      @(negedge clk); timer_match = 1'b1;
      @(negedge clk); timer_match = 1'b0;
      chk("R6", "timer ignored when disabled", int'(busy), 0);
      trig_sel = 2'b10;
      @(negedge clk); timer_match = 1'b1;
      @(negedge clk); timer_match = 1'b0;
      chk("R6", "timer starts", int'(busy), 1);
      wait_idle();
      read_chk(6, 5, 1, 0, "R6");
      // R7: triggers during a conversion are dropped
      trig_sel = 2'b11;
      start_sw(6);
      @(negedge clk); timer_match = 1'b1;
      @(negedge clk); timer_match = 1'b0;
      wait_idle();
      @(negedge clk);
      chk("R7", "timer during busy dropped", int'(busy), 0);
      trig_sel = 2'b00;
      clear_all();
   endtask

   task automatic run_burst(input logic [7:0] m, input int exp0, input int exp1,
                            input int exp2, input int exp3, input string req);
      int seen [4];
      int at [4];
      int cnt = 0;
      chan_mask = m;
      @(negedge clk); burst_en = 1'b1;
      for (int cyc = 0; cyc < 80 && cnt < 4; cyc++) begin
         @(negedge clk);
         if (sample) begin
            seen[cnt] = int'(ana_chan);
            at[cnt] = cyc;
            cnt++;
         end
      end
      burst_en = 1'b0;
      chk(req, "burst samples seen", cnt, 4);
      chk(req, "burst order 0", seen[0], exp0);
      chk(req, "burst order 1", seen[1], exp1);
      chk(req, "burst order 2", seen[2], exp2);
      chk(req, "burst order 3 wrap", seen[3], exp3);
      chk(req, "burst gap", at[2] - at[1], 11);
      chk(req, "burst gap wrap", at[3] - at[2], 11);
      wait_idle();
      @(negedge clk);
      chk(req, "stops after burst off", int'(busy), 0);
   endtask

   task automatic t_burst();
      vin[0] = 10'd11; vin[2] = 10'd222; vin[5] = 10'd555;
      clear_all();
      run_burst(8'b0010_0101, 0, 2, 5, 0, "R4");
      read_chk(0, 11, 1, 1, "R9");
      read_chk(2, 222, 1, 0, "R4");
      read_chk(5, 555, 1, 0, "R4");
      read_chk(1, 100, 0, 0, "R4");
      vin[7] = 10'd1000;
      run_burst(8'b1000_0000, 7, 7, 7, 7, "R4");
      read_chk(7, 1000, 1, 1, "R4");
      // empty mask: idle, and starts are ignored during burst
      chan_mask = 8'h00; trig_sel = 2'b10;
      @(negedge clk); burst_en = 1'b1;
      @(negedge clk); sw_start = 1'b1; timer_match = 1'b1; chan_sel = 3'd3;
      @(negedge clk); sw_start = 1'b0; timer_match = 1'b0;
      repeat (3) @(negedge clk);
      chk("R4", "empty mask idle", int'(busy), 0);
      chk("R7", "start ignored in burst", int'(done_vec[3]), 0);
      burst_en = 1'b0; trig_sel = 2'b00;
   endtask

   task automatic t_irq();
      clear_all();
      irq_en = 8'b0000_0010;
      vin[4] = 10'd300;
      start_sw(4); wait_idle();
      @(negedge clk);
      chk("R10", "irq masked channel", int'(irq), 0);
      vin[1] = 10'd301;
      start_sw(1); wait_idle();
      @(negedge clk);
      chk("R10", "irq enabled channel", int'(irq), 1);
      read_chk(1, 301, 1, 0, "R10");
      chk("R10", "irq after read", int'(irq), 0);
      irq_en = 8'h00;
   endtask

   initial begin
      for (int c = 0; c < 8; c++) vin[c] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sw_conv(3, 0);
      t_sw_conv(6, 1023);
      t_sw_conv(2, 512);
      t_sw_conv(1, 511);
      t_sw_conv(4, 341);
      t_isolation();
      t_sw_busy_ignored();
      t_overrun();
      t_pin_edges();
      t_timer();
      t_burst();
      t_irq();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #3000000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule